// File: doc/BRIEF.md
# Program Sequencer with Return-Address Stack

This block produces the program counter of a small 8-bit microcontroller core. Once per instruction it takes a decoded flow-control command, a condition selector, a 12-bit target address and the current carry and zero flags, and chooses the next PC. The choices are: step to the next instruction, jump, call a subroutine, return from one, or return from an interrupt. Calls and returns go through an internal return-address stack of 30 entries.

An interrupt request is taken at an instruction boundary while interrupts are enabled. The current PC goes onto the stack and the carry and zero flags are captured. Interrupts are then disabled and execution moves to the fixed vector 0xFFF.

An interrupt return pops the stacked address exactly, without adding one. It raises a one-cycle restore strobe, and the execution unit uses that strobe to reload its carry and zero from the captured values. The strobe comes together with the returned PC. Stack misuse is recorded in two sticky flags.

Top module: `prog_seq`

## Requirements
- R1: After reset the PC is 0x000, interrupts are disabled, the captured flags and the restore strobe are 0, both sticky stack flags are 0, and the stack is empty.
- R2: Command 0 (step) loads PC+1, and the PC wraps from 0xFFF to 0x000.
- R3: Command 1 (jump) loads the target when the condition holds, and otherwise loads PC+1. The condition selector codes are: 4 = zero set, 5 = zero clear, 6 = carry set, 7 = carry clear, and any other code = always true.
- R4: Command 2 (call) with a true condition pushes the current PC and loads the target. With a false condition it loads PC+1 and leaves the stack untouched.
- R5: Command 3 (return) with a true condition pops the top entry and loads it plus one. With a false condition it loads PC+1 and leaves the stack untouched.
- R6: Commands 4 and 5 (interrupt return) ignore the condition. They pop the top entry and load it unchanged. Command 4 then enables interrupts and command 5 disables them. In the cycle the popped PC appears, the restore strobe is 1.
- R7: Command 6 enables interrupts and command 7 disables them. Neither changes the PC.
- R8: When the request input is 1 and interrupts are enabled, the command is discarded. The current PC is pushed, carry and zero are captured on the flag outputs, interrupts are disabled, and the PC becomes 0xFFF.
- R9: While interrupts are disabled, the request input has no effect.
- R10: A push onto a full stack (30 entries) overwrites the oldest entry and sets a sticky overflow flag, which stays set until reset.
- R11: A pop from an empty stack sets a sticky underflow flag, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_i | input | 3 | Flow-control command (encodings per R2–R7) |
| cond_i | input | 3 | Condition selector (encoding per R3) |
| target_i | input | 12 | Jump/call target address |
| carry_i | input | 1 | Current carry flag |
| zero_i | input | 1 | Current zero flag |
| irq_i | input | 1 | Interrupt request |
| pc_o | output | 12 | Program counter |
| int_en_o | output | 1 | Interrupt enable |
| rest_carry_o | output | 1 | Carry captured at interrupt entry |
| rest_zero_o | output | 1 | Zero captured at interrupt entry |
| rest_valid_o | output | 1 | Strobe: load captured flags this cycle |
| stk_ovf_o | output | 1 | Sticky stack overflow |
| stk_udf_o | output | 1 | Sticky stack underflow |

## Verification
An interrupt request and a flow-control command can arrive in the same cycle. The interesting case is a call presented with an enabled request. The bench provokes it by presenting that call while a request is active and interrupts are enabled. It judges the result by three observations: the PC goes to the vector rather than the call target, the pushed address is the interrupted PC (shown by the later interrupt return), and the flags captured are the ones driven in that cycle. A request presented while interrupts are disabled must instead leave the ordinary increment intact.

// File: rtl/prog_seq_pkg.sv
package prog_seq_pkg;

    typedef enum logic [2:0] {
        SEQ_STEP     = 3'd0,
        SEQ_JUMP     = 3'd1,
        SEQ_CALL     = 3'd2,
        SEQ_RET      = 3'd3,
        SEQ_RETI_EN  = 3'd4,
        SEQ_RETI_DIS = 3'd5,
        SEQ_IE_SET   = 3'd6,
        SEQ_IE_CLR   = 3'd7
    } seq_cmd_e;

    localparam logic [2:0] COND_ZSET = 3'd4;
    localparam logic [2:0] COND_ZCLR = 3'd5;
    localparam logic [2:0] COND_CSET = 3'd6;
    localparam logic [2:0] COND_CCLR = 3'd7;

endpackage

// File: rtl/seq_cond_eval.sv
module seq_cond_eval
    import prog_seq_pkg::*;
(
    input  logic [2:0] sel_i,
    input  logic       carry_i,
    input  logic       zero_i,
    output logic       pass_o
);
    always_comb begin
        case (sel_i)
            COND_ZSET: pass_o = zero_i;
            COND_ZCLR: pass_o = !zero_i;
            COND_CSET: pass_o = carry_i;
            COND_CCLR: pass_o = !carry_i;
            default:   pass_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/ret_stack.sv
module ret_stack #(
    parameter int DEPTH = 30,
    parameter int AW    = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic          pop_i,
    input  logic [AW-1:0] data_i,
    output logic [AW-1:0] top_o,
    output logic          ovf_o,
    output logic          udf_o
);
    localparam int IW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    typedef struct packed {
        logic [IW-1:0] wptr;
        logic [CW-1:0] cnt;
        logic          ovf;
        logic          udf;
    } stk_state_t;

    stk_state_t    st_q, st_d;
    logic [AW-1:0] mem_q [DEPTH];
    logic [IW-1:0] wptr_inc, top_idx;
    logic          full, empty;

    assign full     = (st_q.cnt == FULL);
    assign empty    = (st_q.cnt == '0);
    assign wptr_inc = (st_q.wptr == LAST) ? '0 : st_q.wptr + 1'b1;
    assign top_idx  = (st_q.wptr == '0) ? LAST : st_q.wptr - 1'b1;
    assign top_o    = mem_q[top_idx];
    assign ovf_o    = st_q.ovf;
    assign udf_o    = st_q.udf;

    always_comb begin
        st_d = st_q;
        if (push_i) begin
            st_d.wptr = wptr_inc;
            if (full) st_d.ovf = 1'b1;
            else      st_d.cnt = st_q.cnt + 1'b1;
        end else if (pop_i) begin
            st_d.wptr = top_idx;
            if (empty) st_d.udf = 1'b1;
            else       st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_slot
            always_ff @(posedge clk) begin
                if (!rst_n)
                    mem_q[g] <= '0;
                else if (push_i && st_q.wptr == IW'(g))
                    mem_q[g] <= data_i;
            end
        end
    endgenerate
endmodule

// File: rtl/prog_seq.sv
module prog_seq
    import prog_seq_pkg::*;
#(
    parameter int PC_W        = 12,
    parameter int STACK_DEPTH = 30,
    parameter logic [PC_W-1:0] VECTOR = '1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2:0]      cmd_i,
    input  logic [2:0]      cond_i,
    input  logic [PC_W-1:0] target_i,
    input  logic            carry_i,
    input  logic            zero_i,
    input  logic            irq_i,
    output logic [PC_W-1:0] pc_o,
    output logic            int_en_o,
    output logic            rest_carry_o,
    output logic            rest_zero_o,
    output logic            rest_valid_o,
    output logic            stk_ovf_o,
    output logic            stk_udf_o
);
    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic            ie;
        logic            sc;
        logic            sz;
        logic            rv;
    } seq_state_t;

    seq_state_t      cur_q, nxt_d;
    logic            cond_pass, take_irq, push_d, pop_d;
    logic [PC_W-1:0] stack_top, pc_inc;
    seq_cmd_e        cmd;

    assign cmd      = seq_cmd_e'(cmd_i);
    assign pc_inc   = cur_q.pc + 1'b1;
    assign take_irq = irq_i && cur_q.ie;

    seq_cond_eval u_cond (
        .sel_i   (cond_i),
        .carry_i (carry_i),
        .zero_i  (zero_i),
        .pass_o  (cond_pass)
    );

    ret_stack #(.DEPTH(STACK_DEPTH), .AW(PC_W)) u_stack (
        .clk    (clk),
        .rst_n  (rst_n),
        .push_i (push_d),
        .pop_i  (pop_d),
        .data_i (cur_q.pc),
        .top_o  (stack_top),
        .ovf_o  (stk_ovf_o),
        .udf_o  (stk_udf_o)
    );

    always_comb begin
        nxt_d    = cur_q;
        nxt_d.rv = 1'b0;
        push_d   = 1'b0;
        pop_d    = 1'b0;
        if (take_irq) begin
            push_d   = 1'b1;
            nxt_d.pc = VECTOR;
            nxt_d.ie = 1'b0;
            nxt_d.sc = carry_i;
            nxt_d.sz = zero_i;
        end else begin
            case (cmd)
                SEQ_STEP: nxt_d.pc = pc_inc;
                SEQ_JUMP: nxt_d.pc = cond_pass ? target_i : pc_inc;
                SEQ_CALL: begin
                    push_d   = cond_pass;
                    nxt_d.pc = cond_pass ? target_i : pc_inc;
                end
                SEQ_RET: begin
                    pop_d    = cond_pass;
                    nxt_d.pc = cond_pass ? stack_top + 1'b1 : pc_inc;
                end
                SEQ_RETI_EN, SEQ_RETI_DIS: begin
                    pop_d    = 1'b1;
                    nxt_d.pc = stack_top;
                    nxt_d.ie = (cmd == SEQ_RETI_EN);
                    nxt_d.rv = 1'b1;
                end
                SEQ_IE_SET: nxt_d.ie = 1'b1;
                SEQ_IE_CLR: nxt_d.ie = 1'b0;
                default:    nxt_d.pc = pc_inc;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign pc_o         = cur_q.pc;
    assign int_en_o     = cur_q.ie;
    assign rest_carry_o = cur_q.sc;
    assign rest_zero_o  = cur_q.sz;
    assign rest_valid_o = cur_q.rv;
endmodule

// File: rtl/prog_seq_checker.sv
module prog_seq_checker #(
    parameter int PC_W = 12,
    parameter logic [PC_W-1:0] VECTOR = '1
) (
    input logic            clk,
    input logic            rst_n,
    input logic [2:0]      cmd_i,
    input logic [2:0]      cond_i,
    input logic [PC_W-1:0] target_i,
    input logic            irq_i,
    input logic [PC_W-1:0] pc_o,
    input logic            int_en_o,
    input logic            rest_valid_o,
    input logic            stk_ovf_o,
    input logic            stk_udf_o,
    input logic [PC_W-1:0] stack_top
);
    logic quiet;
    assign quiet = !(irq_i && int_en_o);

    p_step_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 3'd0 && quiet) |=> pc_o == $past(pc_o) + PC_W'(1));

    p_jump_always_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 3'd1 && cond_i == 3'd0 && quiet) |=> pc_o == $past(target_i));

    p_ret_plus_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 3'd3 && cond_i == 3'd0 && quiet) |=> pc_o == $past(stack_top) + PC_W'(1));

    p_reti_exact_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 3'd4 && quiet) |=> (pc_o == $past(stack_top)) && int_en_o && rest_valid_o);

    p_ie_set_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 3'd6 && quiet) |=> int_en_o && $stable(pc_o));

    p_irq_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_i && int_en_o) |=> (pc_o == VECTOR) && !int_en_o);

    p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stk_ovf_o |=> stk_ovf_o);

    p_udf_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        stk_udf_o |=> stk_udf_o);
endmodule

bind prog_seq prog_seq_checker #(.PC_W(PC_W), .VECTOR(VECTOR)) u_chk (.*);

// File: tb/prog_seq_test.sv
module prog_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cmd_i = '0, cond_i = '0;
    logic [11:0] target_i = '0;
    logic        carry_i = 1'b0, zero_i = 1'b0, irq_i = 1'b0;
    logic [11:0] pc_o;
    logic        int_en_o, rest_carry_o, rest_zero_o, rest_valid_o, stk_ovf_o, stk_udf_o;
    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    prog_seq uut (.*);

    typedef struct packed {
        logic [2:0]  cmd;
        logic [2:0]  cond;
        logic [11:0] tgt;
        logic        c, z, irq;
        logic [11:0] epc;
        logic        eie, esc, esz, erv;
    } vec_t;

    // cmd cond tgt c z irq | pc ie sc sz rv
    localparam vec_t VECS [22] = '{
        '{3'd0, 3'd0, 12'h000, 1'b0, 1'b0, 1'b0, 12'h001, 1'b0, 1'b0, 1'b0, 1'b0}, // R2 step
        '{3'd1, 3'd0, 12'h100, 1'b0, 1'b0, 1'b0, 12'h100, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 always
        '{3'd1, 3'd4, 12'h200, 1'b0, 1'b0, 1'b0, 12'h101, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 Z set, false
        '{3'd1, 3'd4, 12'h200, 1'b0, 1'b1, 1'b0, 12'h200, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 Z set, true
        '{3'd1, 3'd7, 12'h300, 1'b1, 1'b0, 1'b0, 12'h201, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 C clear, false
        '{3'd1, 3'd6, 12'h300, 1'b1, 1'b0, 1'b0, 12'h300, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 C set, true
        '{3'd2, 3'd0, 12'h400, 1'b0, 1'b0, 1'b0, 12'h400, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 push 300
        '{3'd2, 3'd5, 12'h500, 1'b0, 1'b1, 1'b0, 12'h401, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 false
        '{3'd2, 3'd5, 12'h500, 1'b0, 1'b0, 1'b0, 12'h500, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 push 401
        '{3'd3, 3'd6, 12'h000, 1'b0, 1'b0, 1'b0, 12'h501, 1'b0, 1'b0, 1'b0, 1'b0}, // R5 false
        '{3'd3, 3'd0, 12'h000, 1'b0, 1'b0, 1'b0, 12'h402, 1'b0, 1'b0, 1'b0, 1'b0}, // R5 pop 401
        '{3'd3, 3'd0, 12'h000, 1'b0, 1'b0, 1'b0, 12'h301, 1'b0, 1'b0, 1'b0, 1'b0}, // R5 pop 300
        '{3'd6, 3'd0, 12'h000, 1'b0, 1'b0, 1'b0, 12'h301, 1'b1, 1'b0, 1'b0, 1'b0}, // R7 enable
        '{3'd0, 3'd0, 12'h000, 1'b1, 1'b0, 1'b1, 12'hFFF, 1'b0, 1'b1, 1'b0, 1'b0}, // R8 entry
        '{3'd0, 3'd0, 12'h000, 1'b0, 1'b0, 1'b0, 12'h000, 1'b0, 1'b1, 1'b0, 1'b0}, // R2 wrap
        '{3'd4, 3'd6, 12'h000, 1'b0, 1'b0, 1'b0, 12'h301, 1'b1, 1'b1, 1'b0, 1'b1}, // R6 reti+en
        '{3'd2, 3'd0, 12'h010, 1'b0, 1'b1, 1'b1, 12'hFFF, 1'b0, 1'b0, 1'b1, 1'b0}, // R8 beats call
        '{3'd0, 3'd0, 12'h000, 1'b0, 1'b0, 1'b1, 12'h000, 1'b0, 1'b0, 1'b1, 1'b0}, // R9 masked
        '{3'd5, 3'd0, 12'h000, 1'b0, 1'b0, 1'b0, 12'h301, 1'b0, 1'b0, 1'b1, 1'b1}, // R6 reti+dis
        '{3'd7, 3'd0, 12'h000, 1'b0, 1'b0, 1'b0, 12'h301, 1'b0, 1'b0, 1'b1, 1'b0}, // R7 clear
        '{3'd6, 3'd0, 12'h000, 1'b0, 1'b0, 1'b0, 12'h301, 1'b1, 1'b0, 1'b1, 1'b0}, // R7 set
        '{3'd7, 3'd0, 12'h000, 1'b0, 1'b0, 1'b0, 12'h301, 1'b0, 1'b0, 1'b1, 1'b0}  // R7 clear
    };

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] c, input logic [2:0] cd, input logic [11:0] t,
                         input logic cy, input logic zr, input logic rq);
        cmd_i = c; cond_i = cd; target_i = t; carry_i = cy; zero_i = zr; irq_i = rq;
        @(negedge clk);
    endtask

    function automatic string tag_of(input logic [2:0] c, input logic rq, input logic ie);
        if (rq && ie) return "R8";
        if (rq)       return "R9";
        case (c)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4, 3'd5: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        drive(3'd0, 3'd0, 12'h0, 1'b0, 1'b0, 1'b0);
        drive(3'd0, 3'd0, 12'h0, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
    endtask

    task automatic chk_reset_state();
        chk("R1", "pc", 32'(pc_o), 32'h0);
        chk("R1", "ie", 32'(int_en_o), 32'h0);
        chk("R1", "flags", 32'({rest_carry_o, rest_zero_o, rest_valid_o}), 32'h0);
        chk("R1", "sticky", 32'({stk_ovf_o, stk_udf_o}), 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic prev_ie;
        @(negedge clk);
        do_reset();
        chk_reset_state();

        prev_ie = 1'b0;
        for (int i = 0; i < 22; i++) begin
            string t;
            t = tag_of(VECS[i].cmd, VECS[i].irq, prev_ie);
            drive(VECS[i].cmd, VECS[i].cond, VECS[i].tgt, VECS[i].c, VECS[i].z, VECS[i].irq);
            chk(t, "pc", 32'(pc_o), 32'(VECS[i].epc));
            chk(t, "ie", 32'(int_en_o), 32'(VECS[i].eie));
            chk(t, "saved c/z", 32'({rest_carry_o, rest_zero_o}), 32'({VECS[i].esc, VECS[i].esz}));
            chk(t, "restore", 32'(rest_valid_o), 32'(VECS[i].erv));
            prev_ie = VECS[i].eie;
        end
        chk("R11", "no underflow yet", 32'(stk_udf_o), 32'h0);

        // R10: 31 calls from a fresh stack, pushed values 0..30
        do_reset();
        chk_reset_state();
        for (int i = 0; i < 31; i++) begin
            drive(3'd2, 3'd0, 12'(i + 1), 1'b0, 1'b0, 1'b0);
            if (i == 29) chk("R10", "ovf at full", 32'(stk_ovf_o), 32'h0);
        end
        chk("R10", "ovf set", 32'(stk_ovf_o), 32'h1);
        chk("R10", "pc after calls", 32'(pc_o), 32'd31);
        for (int i = 0; i < 30; i++) begin
            drive(3'd3, 3'd0, 12'h0, 1'b0, 1'b0, 1'b0);
            if (i == 0)  chk("R10", "newest return", 32'(pc_o), 32'd31);
            if (i == 29) chk("R10", "oldest kept return", 32'(pc_o), 32'd2);
        end
        chk("R10", "ovf sticky", 32'(stk_ovf_o), 32'h1);
        chk("R11", "no udf while filled", 32'(stk_udf_o), 32'h0);
        drive(3'd3, 3'd0, 12'h0, 1'b0, 1'b0, 1'b0);
        chk("R11", "udf set", 32'(stk_udf_o), 32'h1);
        drive(3'd0, 3'd0, 12'h0, 1'b0, 1'b0, 1'b0);
        chk("R11", "udf sticky", 32'(stk_udf_o), 32'h1);

        // R1: reset mid-run empties the stack and clears everything
        drive(3'd6, 3'd0, 12'h0, 1'b0, 1'b0, 1'b0);
        do_reset();
        chk_reset_state();
        drive(3'd3, 3'd0, 12'h0, 1'b0, 1'b0, 1'b0);
        chk("R1", "stack empty after reset", 32'(stk_udf_o), 32'h1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule